// File: doc/BRIEF.md
# Synchronous Serial Clock Edge Engine

This block handles the clocking side of a serial port that runs in synchronous mode. It turns a serial clock into two single-cycle strobes in the system clock domain. One strobe, `tx_change`, tells the transmit shifter when to put out the next bit. The other, `rx_sample`, tells the receive shifter when to capture a bit. In master mode the block generates the serial clock itself from a programmable divider and drives it onto the clock pin. In slave mode it takes an external serial clock from the pin, passes it through a two-flop synchronizer and an edge detector, and derives the strobes from the detected edges.

A polarity input picks which serial clock edge moves the transmit data and which captures the receive data. The two jobs always fall on opposite edges. Shifting data and framing belong to the neighbouring blocks.

Top module: `sck_edge_engine`

## Requirements
- R1: In slave mode, a change of `sck_in` that is first sampled at system clock edge k makes its strobe visible during the cycle that follows edge k+1, which is a fixed two-cycle latency. No strobe appears after edge k itself.
- R2: Every detected serial clock edge produces a strobe exactly one system clock cycle wide.
- R3: With `polarity` = 0, a rising serial clock edge produces `tx_change` and a falling edge produces `rx_sample`.
- R4: With `polarity` = 1, a falling serial clock edge produces `tx_change` and a rising edge produces `rx_sample`.
- R5: `tx_change` and `rx_sample` are never high in the same cycle.
- R6: In master mode with `divider` = D, `sck_out` starts low and toggles once every D+1 system clock cycles.
- R7: In master mode a strobe appears in exactly the cycle in which `sck_out` shows its new level, using the same polarity mapping as R3 and R4.
- R8: `sck_oe` is high exactly when `enable` = 1 and `master` = 1.
- R9: While `enable` = 0, both strobes are low, and `sck_out` is low from the first clock edge after the block is disabled.
- R10: After reset, `sck_out`, `tx_change` and `rx_sample` are low.
- R11: In master mode, toggles on `sck_in` have no effect on any output. In slave mode, `sck_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Turns on the clock engine and its strobes |
| master | input | 1 | 1 = generate the serial clock, 0 = follow the external clock |
| polarity | input | 1 | Selects which serial clock edge changes the data and which samples it |
| divider | input | DIV_W | Half-period of the generated clock, minus one, in system cycles |
| sck_in | input | 1 | Serial clock pin, input side |
| sck_out | output | 1 | Serial clock pin, output side |
| sck_oe | output | 1 | Serial clock pin output enable |
| tx_change | output | 1 | One-cycle pulse: shift out the next transmit bit |
| rx_sample | output | 1 | One-cycle pulse: capture the receive bit |

## Verification
On every cycle the assertions check the following:
- the strobes never overlap and each lasts one cycle;
- in slave mode, every strobe corresponds to a level change of `sck_in` seen two and three cycles earlier, in the direction that the polarity requires;
- every master-mode transition of `sck_out` carries a strobe;
- the outputs stay quiet while the block is disabled.

Other behaviour only the bench scenarios can show. These are the exact divider period, the absence of strobes from `sck_in` activity in master mode, and the exact cycle at which a strobe first appears after an external edge. The bench shows them by checking each cycle against a behavioural model while it changes mode, polarity and divider setting.

// File: rtl/sck_edge_pkg.sv
package sck_edge_pkg;

    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        MODE_SLAVE  = 1'b0,
        MODE_MASTER = 1'b1
    } sck_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edges_t;

    typedef struct packed {
        logic change;
        logic sample;
    } sck_strobes_t;

    // Polarity 0: change on rise, sample on fall. Polarity 1: swapped.
    function automatic sck_strobes_t map_edges(input sck_edges_t e, input logic pol);
        sck_strobes_t s;
        if (pol) begin
            s.change = e.fall;
            s.sample = e.rise;
        end else begin
            s.change = e.rise;
            s.sample = e.fall;
        end
        return s;
    endfunction

endpackage

// File: rtl/sck_sync_edge.sv
module sck_sync_edge
    import sck_edge_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_in,
    output sck_edges_t edges
);
    logic [STAGES-1:0] sync_q;
    logic              delay_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= pin_in;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) sync_q[i] <= 1'b0;
            else     sync_q[i] <= sync_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) delay_q <= 1'b0;
        else     delay_q <= sync_q[STAGES-1];
    end

    always_comb begin
        edges.rise = sync_q[STAGES-1] & ~delay_q;
        edges.fall = ~sync_q[STAGES-1] & delay_q;
    end
endmodule

// File: rtl/sck_divider.sv
module sck_divider
    import sck_edge_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] divider,
    output logic             level,
    output sck_edges_t       edges
);
    logic [DIV_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count_q <= '0;
            level   <= 1'b0;
            edges   <= '0;
        end else if (count_q >= divider) begin
            count_q    <= '0;
            level      <= ~level;
            edges.rise <= ~level;
            edges.fall <= level;
        end else begin
            count_q <= count_q + 1'b1;
            edges   <= '0;
        end
    end
endmodule

// File: rtl/sck_strobe_gate.sv
module sck_strobe_gate
    import sck_edge_pkg::*;
(
    input  logic         active,
    input  logic         polarity,
    input  sck_edges_t   edges,
    output sck_strobes_t strobes
);
    sck_strobes_t mapped;

    always_comb begin
        mapped  = map_edges(edges, polarity);
        strobes = active ? mapped : '0;
    end
endmodule

// File: rtl/sck_edge_engine.sv
module sck_edge_engine
    import sck_edge_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             master,
    input  logic             polarity,
    input  logic [DIV_W-1:0] divider,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_oe,
    output logic             tx_change,
    output logic             rx_sample
);
    sck_mode_e    mode;
    sck_edges_t   ext_edges;
    sck_edges_t   gen_edges;
    sck_edges_t   sel_edges;
    sck_strobes_t strobes;
    logic         gen_level;
    logic         gen_run;

    assign mode    = sck_mode_e'(master);
    assign gen_run = enable && (mode == MODE_MASTER);

    sck_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (sck_in),
        .edges  (ext_edges)
    );

    sck_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (gen_run),
        .divider (divider),
        .level   (gen_level),
        .edges   (gen_edges)
    );

    assign sel_edges = (mode == MODE_MASTER) ? gen_edges : ext_edges;

    sck_strobe_gate u_gate (
        .active   (enable),
        .polarity (polarity),
        .edges    (sel_edges),
        .strobes  (strobes)
    );

    assign sck_out   = gen_level;
    assign sck_oe    = gen_run;
    assign tx_change = strobes.change;
    assign rx_sample = strobes.sample;
endmodule

// File: rtl/sck_edge_engine_checker.sv
module sck_edge_engine_checker (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic master,
    input logic polarity,
    input logic sck_in,
    input logic sck_out,
    input logic tx_change,
    input logic rx_sample
);
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
    end
    logic warm;
    assign warm = (since_rst >= 3'd4);

    logic slave_on;
    assign slave_on = enable && !master;

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        !(tx_change && rx_sample));

    assert_tx_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        tx_change |=> !tx_change);

    assert_rx_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        rx_sample |=> !rx_sample);

    assert_slave_latency_R1: assert property (@(posedge clk) disable iff (rst)
        (warm && slave_on && (tx_change || rx_sample)) |-> ($past(sck_in, 2) != $past(sck_in, 3)));

    assert_pol0_direction_R3: assert property (@(posedge clk) disable iff (rst)
        (warm && slave_on && !polarity && tx_change) |-> $past(sck_in, 2));

    assert_pol1_direction_R4: assert property (@(posedge clk) disable iff (rst)
        (warm && slave_on && polarity && tx_change) |-> !$past(sck_in, 2));

    assert_master_edge_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (warm && enable && master && $past(enable && master) && (sck_out != $past(sck_out)))
            |-> (tx_change || rx_sample));

    assert_quiet_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        (warm && !enable && $past(!enable)) |-> (!tx_change && !rx_sample && !sck_out));
endmodule

bind sck_edge_engine sck_edge_engine_checker u_checker (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .master    (master),
    .polarity  (polarity),
    .sck_in    (sck_in),
    .sck_out   (sck_out),
    .tx_change (tx_change),
    .rx_sample (rx_sample)
);

// File: tb/tb_sck_edge_engine.sv
module tb_sck_edge_engine;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic             master = 1'b0;
    logic             polarity = 1'b0;
    logic [DIV_W-1:0] divider = '0;
    logic             sck_in = 1'b0;
    logic             sck_out, sck_oe, tx_change, rx_sample;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sck_edge_engine #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .enable(enable), .master(master),
        .polarity(polarity), .divider(divider), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe),
        .tx_change(tx_change), .rx_sample(rx_sample)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: sample history and a generated-clock model.
    int h0 = 0, h1 = 0, h2 = 0;
    int m_cnt = 0, m_lvl = 0, m_rise = 0, m_fall = 0;

    always @(posedge clk) begin
        if (rst) begin
            h0 = 0; h1 = 0; h2 = 0;
            m_cnt = 0; m_lvl = 0; m_rise = 0; m_fall = 0;
        end else begin
            h2 = h1; h1 = h0; h0 = int'(sck_in);
            if (!(enable && master)) begin
                m_cnt = 0; m_lvl = 0; m_rise = 0; m_fall = 0;
            end else if (m_cnt >= int'(divider)) begin
                m_cnt = 0;
                m_lvl = 1 - m_lvl;
                m_rise = m_lvl;
                m_fall = 1 - m_lvl;
            end else begin
                m_cnt++;
                m_rise = 0; m_fall = 0;
            end
        end
    end

    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            int rise, fall, etx, erx;
            string sreq;
            rise = master ? m_rise : (h1 && !h2);
            fall = master ? m_fall : (!h1 && h2);
            etx  = enable ? (polarity ? fall : rise) : 0;
            erx  = enable ? (polarity ? rise : fall) : 0;
            if (!enable)     sreq = "R9";
            else if (master) sreq = "R7";
            else if (polarity) sreq = "R4";
            else             sreq = "R3";
            check(sreq, "tx_change", int'(tx_change), etx);
            check(sreq, "rx_sample", int'(rx_sample), erx);
            check(master ? "R6" : "R11", "sck_out", int'(sck_out), m_lvl);
            check("R8", "sck_oe", int'(sck_oe), int'(enable && master));
            check("R5", "strobe overlap", int'(tx_change && rx_sample), 0);
        end
    end

    task automatic toggle_ext(input int half, input int n);
        for (int i = 0; i < n; i++) begin
            repeat (half) @(negedge clk);
            sck_in = ~sck_in;
        end
    endtask

    task automatic latency_probe(input logic pol);
        // sck_in is low and settled; drive a rise, then a fall.
        bit want_tx;
        @(negedge clk);
        sck_in = 1'b1;
        want_tx = !pol;
        @(negedge clk); #1;
        check("R1", "no strobe after first edge", int'(tx_change || rx_sample), 0);
        @(negedge clk); #1;
        check("R1", "rise strobe after two edges", int'(want_tx ? tx_change : rx_sample), 1);
        @(negedge clk); #1;
        check("R2", "strobe one cycle wide", int'(tx_change || rx_sample), 0);
        repeat (4) @(negedge clk);
        sck_in = 1'b0;
        repeat (2) @(negedge clk); #1;
        check("R1", "fall strobe after two edges", int'(want_tx ? rx_sample : tx_change), 1);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R10", "sck_out in reset", int'(sck_out), 0);
        check("R10", "tx_change in reset", int'(tx_change), 0);
        check("R10", "rx_sample in reset", int'(rx_sample), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R10", "sck_out after reset", int'(sck_out), 0);

        // Slave, polarity 0
        enable = 1'b1; master = 1'b0; polarity = 1'b0;
        repeat (4) @(negedge clk);
        latency_probe(1'b0);
        toggle_ext(4, 20);
        toggle_ext(3, 12);
        if (sck_in) toggle_ext(4, 1);
        repeat (6) @(negedge clk);

        // Slave, polarity 1
        polarity = 1'b1;
        repeat (4) @(negedge clk);
        latency_probe(1'b1);
        toggle_ext(5, 16);
        repeat (6) @(negedge clk);

        // Disabled while the pin toggles
        enable = 1'b0;
        toggle_ext(4, 10);
        if (sck_in) toggle_ext(4, 1);
        repeat (6) @(negedge clk);

        // Master, divider 3, polarity 0, pin activity must be ignored
        enable = 1'b1; master = 1'b1; polarity = 1'b0; divider = 8'd3;
        @(negedge clk); #1;
        check("R8", "oe in master", int'(sck_oe), 1);
        toggle_ext(3, 20);
        repeat (40) @(negedge clk);

        // Master, divider 0, polarity 1
        enable = 1'b0;
        repeat (2) @(negedge clk);
        enable = 1'b1; polarity = 1'b1; divider = 8'd0;
        repeat (30) @(negedge clk);

        // Master, divider 6
        enable = 1'b0;
        repeat (2) @(negedge clk);
        enable = 1'b1; divider = 8'd6; polarity = 1'b0;
        repeat (60) @(negedge clk);

        // Back to slave: sck_out must drop and stay low
        master = 1'b0;
        toggle_ext(4, 8);
        repeat (8) @(negedge clk); #1;
        check("R11", "sck_out low in slave", int'(sck_out), 0);
        check("R8", "oe low in slave", int'(sck_oe), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule